// File: doc/BRIEF.md
# Low-Transition Scan-In Pattern Reorderer

This block feeds one scan chain during built-in self test. An internal 4-bit maximal-length LFSR supplies one pseudo-random word per pattern. Before the word is shifted into the chain, its bits are rearranged so that every 0 goes in before every 1. As a result, the scan input changes value at most once inside a pattern. The reordering keeps the number of ones in the word and changes only their order. No storage is added for it: the serial bit is computed from the current LFSR word and the shift position.

The controller raises `scan_en` for each clock that should move one bit into the chain. A `pattern_done` pulse marks the shift that finishes a word, and the LFSR then steps to its next state. A `bypass` input shifts the raw LFSR order instead, which gives a baseline to compare against. A saturating counter records every change of the scan-input value between consecutive shifts, including the change across a pattern boundary. The two modes can therefore be compared by their toggle totals.

Top module: `lt_scan_reorder`

## Requirements
- R1: While `rst_n` is low, the LFSR loads the seed 4'b0001, the shift position goes to 0 and `toggle_count` goes to 0.
- R2: The LFSR steps once per completed pattern as {s[2:0], s[3]^s[2]} (polynomial x^4+x^3+1). It repeats with period 15 and never reaches zero.
- R3: With `bypass` low, a pattern holding z zero bits drives `scan_out` to 0 on its first z shifts and to 1 on the rest.
- R4: With `bypass` high, a pattern is shifted raw: s[3] first, then s[2], s[1] and s[0].
- R5: Exactly one bit moves per clock while `scan_en` is high. With `scan_en` low, the position, the LFSR and the counter hold, so a paused pattern resumes where it stopped.
- R6: `pattern_done` is high exactly in the cycle of the fourth shift of a pattern, and low at all other times.
- R7: `toggle_count` goes up by one on each shift whose bit differs from the previously shifted bit, including the step across a pattern boundary. The first shift after reset never counts.
- R8: `toggle_count` saturates at its all-ones value and never wraps.
- R9: For the word 1010, a raw shift toggles 3 times inside the pattern and a reordered shift toggles once. A reordered pattern never shows a 1 followed by a 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_en | input | 1 | Shift one bit this cycle |
| bypass | input | 1 | 1 = raw LFSR order, 0 = zeros-first order |
| scan_out | output | 1 | Serial bit to the scan chain |
| pattern_done | output | 1 | Final shift of the current pattern |
| toggle_count | output | CW | Saturating count of scan-input value changes |

## Verification
A wrong LFSR state shows up on the first shift of the next pattern, as a wrong bit in bypass mode or a wrong zero count in reorder mode. A wrong shift position shows up at once as a misplaced `pattern_done` pulse or a misplaced 0-to-1 step. A counter fault shows up in the toggle total checked at the end of every pattern. A missed boundary transition shows up within the first shift of the next pattern.

// File: rtl/lt_scan_reorder.sv
module lt_scan_reorder #(
  parameter int W = 4,
  parameter logic [W-1:0] TAPS = 4'b1100,
  parameter logic [W-1:0] SEED = 4'b0001,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scan_en,
  input  logic          bypass,
  output logic          scan_out,
  output logic          pattern_done,
  output logic [CW-1:0] toggle_count
);
  localparam int PW = $clog2(W);
  localparam int OW = $clog2(W + 1);

  logic [W-1:0]  lfsr;
  logic [PW-1:0] pos;
  logic [OW-1:0] ones;
  logic          last_bit, have_last;

  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) ones = ones + OW'(lfsr[i]);
  end

  assign scan_out = bypass ? lfsr[PW'(W-1) - pos]
                           : (int'(pos) >= W - int'(ones));
  assign pattern_done = scan_en && (pos == PW'(W-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr <= SEED;
      pos <= '0;
    end else if (scan_en) begin
      if (pattern_done) begin
        pos <= '0;
        lfsr <= {lfsr[W-2:0], ^(lfsr & TAPS)};
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      toggle_count <= '0;
      last_bit <= 1'b0;
      have_last <= 1'b0;
    end else if (scan_en) begin
      last_bit <= scan_out;
      have_last <= 1'b1;
      if (have_last && scan_out != last_bit && toggle_count != '1)
        toggle_count <= toggle_count + 1'b1;
    end
  end

  // R2
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) lfsr != '0);
  // R6
  done_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n) pattern_done |-> scan_en);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) pattern_done |=> !pattern_done);
  // R8
  count_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> toggle_count >= $past(toggle_count));
  // R5
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> $stable(toggle_count) && $stable(lfsr));
  // R9
  zeros_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && !bypass && $past(scan_en && !bypass) && pos != '0 && last_bit) |-> scan_out);
endmodule

// File: tb/lt_scan_reorder_test.sv
module lt_scan_reorder_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, scan_en = 1'b0, bypass = 1'b0;
  logic scan_out, pattern_done;
  logic [15:0] toggle_count;

  logic s_en = 1'b0;
  logic s_out, s_done;
  logic [3:0] s_cnt;

  lt_scan_reorder uut (.clk(clk), .rst_n(rst_n), .scan_en(scan_en), .bypass(bypass),
    .scan_out(scan_out), .pattern_done(pattern_done), .toggle_count(toggle_count));

  lt_scan_reorder #(.CW(4)) uut_sat (.clk(clk), .rst_n(rst_n), .scan_en(s_en), .bypass(1'b1),
    .scan_out(s_out), .pattern_done(s_done), .toggle_count(s_cnt));

  typedef struct { logic b; logic d; logic byp; } exp_t;
  exp_t q[$];
  int errors = 0, checks = 0;
  bit finished = 0;

  logic [3:0] m_lfsr;
  logic m_last;
  bit m_have;
  int m_cnt;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && scan_en) begin
      if (q.size() == 0) chk(0, "R5 unexpected shift", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(scan_out === e.b, e.byp ? "R4 raw bit" : "R3 reordered bit", scan_out, e.b);
        chk(pattern_done === e.d, "R6 done pulse", pattern_done, e.d);
      end
    end else if (rst_n) begin
      chk(pattern_done === 1'b0, "R6 done idle", pattern_done, 0);
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; scan_en = 1'b0; s_en = 1'b0;
    q.delete();
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    m_lfsr = 4'b0001; m_have = 0; m_cnt = 0; m_last = 0;
    chk(toggle_count === 16'd0, "R1 count reset", toggle_count, 0);
  endtask

  task automatic run_pattern(input logic byp, input int stall_at);
    logic [3:0] bits;
    int ones;
    ones = m_lfsr[0] + m_lfsr[1] + m_lfsr[2] + m_lfsr[3];
    for (int p = 0; p < 4; p++) begin
      exp_t e;
      bits[p] = byp ? m_lfsr[3-p] : (p >= 4 - ones);
      e.b = bits[p]; e.d = (p == 3); e.byp = byp;
      q.push_back(e);
    end
    for (int p = 0; p < 4; p++) begin
      if (p == stall_at) begin
        scan_en = 1'b0;
        repeat (3) @(posedge clk);
        #1;
      end
      scan_en = 1'b1; bypass = byp;
      @(posedge clk); #1;
      if (m_have && bits[p] != m_last && m_cnt < 65535) m_cnt++;
      m_last = bits[p]; m_have = 1;
    end
    scan_en = 1'b0;
    m_lfsr = {m_lfsr[2:0], m_lfsr[3] ^ m_lfsr[2]};
    chk(toggle_count == m_cnt, "R7 toggle total", toggle_count, m_cnt);
  endtask

  int before7, delta, raw_total, ord_total;

  initial begin
    do_reset();
    // R2, R3 reordered mode across a full LFSR period plus one, with pauses (R5)
    for (int n = 0; n < 16; n++) begin
      if (n == 7) before7 = toggle_count;
      run_pattern(1'b0, (n % 5 == 2) ? 1 : -1);
      if (n == 7) begin
        delta = toggle_count - before7;
        chk(delta == 2, "R9 reordered 1010 boundary+inner", delta, 2);
      end
    end
    ord_total = toggle_count;
    repeat (3) @(posedge clk);
    #1 chk(toggle_count == ord_total, "R5 idle hold", toggle_count, ord_total);

    do_reset();
    for (int n = 0; n < 16; n++) begin
      if (n == 7) before7 = toggle_count;
      run_pattern(1'b1, (n % 4 == 1) ? 2 : -1);
      if (n == 7) begin
        delta = toggle_count - before7;
        chk(delta == 3, "R9 raw 1010 toggles", delta, 3);
      end
    end
    raw_total = toggle_count;
    chk(raw_total > ord_total, "R9 reorder saves toggles", ord_total, raw_total);

    // R8 saturation on a narrow counter
    do_reset();
    s_en = 1'b1;
    repeat (80) @(posedge clk);
    #1 chk(s_cnt == 4'd15, "R8 saturate", s_cnt, 15);
    repeat (8) @(posedge clk);
    #1 chk(s_cnt == 4'd15, "R8 no wrap", s_cnt, 15);
    s_en = 1'b0;

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule